// File: doc/BRIEF.md
# Ring Queue Pointer Bank

A bank of hardware ring-queue pointer pairs reached through a plain 32-bit register port. Each queue keeps an 18-bit read pointer, an 18-bit write pointer, a count of occupied entries and a power-of-two ring size. Software never loads a pointer directly. It moves a pointer by writing a small increment to that queue's read-add or write-add register, and it reads the pointer back through a status register whose upper bits carry the queue's sticky error flags.

The register space is a fixed region in which every queue owns a window of 0x800 bytes. The window is chosen by the address bits above bit 10, and the offset inside the window selects the register. A producer advances the write pointer after it fills entries. A consumer advances the read pointer after it drains them. The block refuses any move that would let the producer lap the consumer or let the consumer pass the producer, and it records the attempt in a flag.

The register port has no back-pressure. A write takes effect at the clock edge where it is sampled. A read is answered one cycle later with a valid strobe, and it cannot be stalled.

Top module: `qptr_bank`

## Requirements
- R1: An address maps to a register only when bit 19 is 1, the queue index in bits 18:11 is below NUM_Q, and bits 10:0 equal one of 0x000, 0x004, 0x008, 0x00C or 0x010. A write to any other address changes no queue. A read of any other address returns 0.
- R2: A write to offset 0x004 adds the increment to the write pointer. A write to offset 0x000 adds the increment to the read pointer. Both pointers wrap modulo the queue's ring size.
- R3: A read of offset 0x008 returns the read pointer in bits 17:0, and a read of offset 0x00C returns the write pointer in bits 17:0. In both words bit 18 is the overflow flag, bit 19 the underflow flag, bit 20 the clamp flag, and bits 31:21 are 0.
- R4: If any bit from 31 to 6 of an add value is set, the increment used is 63 and the clamp flag (bit 20) is set. The flag stays set until the queue is reconfigured or the block is reset.
- R5: A write-pointer add that would make the occupancy exceed the ring size leaves the pointer and the occupancy unchanged and sets the sticky overflow flag (bit 18).
- R6: A read-pointer add larger than the occupancy leaves the pointer and the occupancy unchanged and sets the sticky underflow flag (bit 19).
- R7: A write to offset 0x010 sets the size code from bits 3:0. The ring size is 256 << code, and codes above 10 saturate to 10. The same write clears that queue's pointers, occupancy and flags. A read of offset 0x010 returns the code in bits 3:0.
- R8: `rvalid` is high in exactly the cycle after each cycle in which `rd_en` is high. When a read and a write occur in the same cycle, the read returns the state from before the write.
- R9: After reset, every queue has both pointers at 0, all flags clear and size code 0 (256 entries).
- R10: An operation on one queue changes no other queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 20 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |

## Verification
A corrupted pointer appears in the next status read of that queue, one cycle after the read is requested. A desynchronised occupancy count is harder to see. It appears only later, when an overflow or underflow flag rises where the pointer arithmetic says it should not, or fails to rise where it should, possibly many adds after the fault. The bench therefore tracks occupancy in an arithmetic model and pushes queues to both exact boundaries. A decode fault that hits the wrong queue shows up because every queue is read back after each phase.

// File: rtl/qpb_pkg.sv
package qpb_pkg;

  localparam int DATA_W   = 32;
  localparam int PTR_W    = 18;
  localparam int CNT_W    = PTR_W + 1;
  localparam int MIN_LOG2 = 8;
  localparam int CODE_MAX = PTR_W - MIN_LOG2;
  localparam int CODE_W   = $clog2(CODE_MAX + 1);
  localparam int ADD_MAX  = 63;
  localparam int ADD_W    = $clog2(ADD_MAX + 1);
  localparam int FLAG_LSB = PTR_W;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ADD_RD,
    SEL_ADD_WR,
    SEL_STS_RD,
    SEL_STS_WR,
    SEL_SIZE
  } reg_sel_t;

  typedef struct packed {
    logic [PTR_W-1:0]  rp;
    logic [PTR_W-1:0]  wp;
    logic [CNT_W-1:0]  occ;
    logic [CODE_W-1:0] code;
    logic              ovf;
    logic              unf;
    logic              clp;
  } qent_t;

  function automatic logic [CNT_W-1:0] ring_size(input logic [CODE_W-1:0] c);
    return CNT_W'(1) << (MIN_LOG2 + int'(c));
  endfunction

  function automatic logic [PTR_W-1:0] ring_mask(input logic [CODE_W-1:0] c);
    logic [CNT_W-1:0] s;
    s = ring_size(c) - CNT_W'(1);
    return s[PTR_W-1:0];
  endfunction

endpackage

// File: rtl/qpb_decode.sv
module qpb_decode #(
  parameter int                ADDR_W = 20,
  parameter int                QIDX_W = 8,
  parameter int                WIN_W  = 11,
  parameter int                NUM_Q  = 256,
  parameter logic [ADDR_W-1:0] BASE   = 20'h80000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [QIDX_W-1:0] qidx,
  output qpb_pkg::reg_sel_t sel,
  output logic              hit
);
  import qpb_pkg::*;

  localparam int SPAN = QIDX_W + WIN_W;

  logic             in_region;
  logic             in_range;
  logic [WIN_W-1:0] off;

  assign in_region = (addr[ADDR_W-1:SPAN] == BASE[ADDR_W-1:SPAN]);
  assign qidx      = addr[SPAN-1:WIN_W];
  assign off       = addr[WIN_W-1:0];
  assign in_range  = ({1'b0, qidx} < (QIDX_W+1)'(NUM_Q));

  always_comb begin
    sel = SEL_NONE;
    if (in_region && in_range) begin
      case (off)
        WIN_W'(12'h000): sel = SEL_ADD_RD;
        WIN_W'(12'h004): sel = SEL_ADD_WR;
        WIN_W'(12'h008): sel = SEL_STS_RD;
        WIN_W'(12'h00C): sel = SEL_STS_WR;
        WIN_W'(12'h010): sel = SEL_SIZE;
        default:         sel = SEL_NONE;
      endcase
    end
  end

  assign hit = (sel != SEL_NONE);

endmodule

// File: rtl/qpb_step.sv
module qpb_step (
  input  qpb_pkg::qent_t          cur,
  input  qpb_pkg::reg_sel_t       sel,
  input  logic [qpb_pkg::DATA_W-1:0] wdata,
  output qpb_pkg::qent_t          nxt
);
  import qpb_pkg::*;

  logic              big;
  logic [ADD_W-1:0]  inc;
  logic [CNT_W:0]    occ_up;
  logic [CNT_W-1:0]  size;
  logic [PTR_W-1:0]  mask;
  logic [CODE_W-1:0] new_code;

  assign big    = |wdata[DATA_W-1:ADD_W];
  assign inc    = big ? ADD_W'(ADD_MAX) : wdata[ADD_W-1:0];
  assign size   = ring_size(cur.code);
  assign mask   = ring_mask(cur.code);
  assign occ_up = {1'b0, cur.occ} + (CNT_W+1)'(inc);
  assign new_code = (wdata[3:0] > 4'(CODE_MAX)) ? CODE_W'(CODE_MAX)
                                                : CODE_W'(wdata[3:0]);

  always_comb begin
    nxt = cur;
    case (sel)
      SEL_ADD_WR: begin
        nxt.clp = cur.clp | big;
        if (occ_up > {1'b0, size}) begin
          nxt.ovf = 1'b1;
        end else begin
          nxt.wp  = (cur.wp + PTR_W'(inc)) & mask;
          nxt.occ = occ_up[CNT_W-1:0];
        end
      end
      SEL_ADD_RD: begin
        nxt.clp = cur.clp | big;
        if (CNT_W'(inc) > cur.occ) begin
          nxt.unf = 1'b1;
        end else begin
          nxt.rp  = (cur.rp + PTR_W'(inc)) & mask;
          nxt.occ = cur.occ - CNT_W'(inc);
        end
      end
      SEL_SIZE: begin
        nxt      = '0;
        nxt.code = new_code;
      end
      default: nxt = cur;
    endcase
  end

endmodule

// File: rtl/qpb_rdfmt.sv
module qpb_rdfmt (
  input  qpb_pkg::qent_t             ent,
  input  qpb_pkg::reg_sel_t          sel,
  output logic [qpb_pkg::DATA_W-1:0] word
);
  import qpb_pkg::*;

  logic [2:0] flags;
  assign flags = {ent.clp, ent.unf, ent.ovf};

  always_comb begin
    word = '0;
    case (sel)
      SEL_STS_RD: word = {{(DATA_W-FLAG_LSB-3){1'b0}}, flags, ent.rp};
      SEL_STS_WR: word = {{(DATA_W-FLAG_LSB-3){1'b0}}, flags, ent.wp};
      SEL_SIZE:   word = DATA_W'(ent.code);
      default:    word = '0;
    endcase
  end

endmodule

// File: rtl/qptr_bank.sv
module qptr_bank #(
  parameter int                NUM_Q  = 256,
  parameter int                ADDR_W = 20,
  parameter int                QIDX_W = 8,
  parameter int                WIN_W  = 11,
  parameter logic [ADDR_W-1:0] BASE   = 20'h80000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [qpb_pkg::DATA_W-1:0] wdata,
  output logic [qpb_pkg::DATA_W-1:0] rdata,
  output logic                       rvalid
);
  import qpb_pkg::*;

  localparam int IDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

  logic [QIDX_W-1:0] qidx;
  logic [IDX_W-1:0]  qi;
  reg_sel_t          sel;
  logic              hit;
  qent_t             qtab [NUM_Q];
  qent_t             cur;
  qent_t             nxt;
  logic [DATA_W-1:0] rword;

  qpb_decode #(
    .ADDR_W(ADDR_W), .QIDX_W(QIDX_W), .WIN_W(WIN_W),
    .NUM_Q(NUM_Q), .BASE(BASE)
  ) i_dec (
    .addr(addr), .qidx(qidx), .sel(sel), .hit(hit)
  );

  assign qi  = IDX_W'(qidx);
  assign cur = hit ? qtab[qi] : '0;

  qpb_step i_step (.cur(cur), .sel(sel), .wdata(wdata), .nxt(nxt));

  qpb_rdfmt i_fmt (.ent(cur), .sel(sel), .word(rword));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_Q; i++) qtab[i] <= '0;
    end else if (wr_en && hit) begin
      qtab[qi] <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rword;
    end
  end

  // R8
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  // R8
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);
  // R1
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> (rdata == '0));
  // R4
  clamp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel == SEL_ADD_RD || sel == SEL_ADD_WR) && (|wdata[DATA_W-1:ADD_W]))
    |=> qtab[$past(qi)].clp);
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit) |=> (qtab[$past(qi)].occ <= ring_size(qtab[$past(qi)].code)));
  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit && sel != SEL_SIZE && cur.ovf) |=> qtab[$past(qi)].ovf);
  // R2
  ptr_occ_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit) |=>
      (((qtab[$past(qi)].wp - qtab[$past(qi)].rp) & ring_mask(qtab[$past(qi)].code))
        == (qtab[$past(qi)].occ[PTR_W-1:0] & ring_mask(qtab[$past(qi)].code))));
  // R7
  size_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_SIZE) |=>
      (qtab[$past(qi)].rp == '0 && qtab[$past(qi)].wp == '0 && qtab[$past(qi)].occ == '0));

endmodule

// File: tb/test_qptr_bank.sv
module test_qptr_bank;
  localparam int NQ = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [19:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;

  int vectors = 0;
  int errors  = 0;

  int mr[NQ], mw[NQ], mocc[NQ], mcode[NQ];
  bit mo[NQ], mu[NQ], mc[NQ];

  always #4 clk = ~clk;

  qptr_bank #(.NUM_Q(NQ)) i_qptr_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  function automatic logic [19:0] qa(input int q, input int off);
    return 20'h80000 | 20'(q << 11) | 20'(off);
  endfunction

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [19:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic m_clear(input int q, input int code);
    mr[q] = 0; mw[q] = 0; mocc[q] = 0; mcode[q] = code;
    mo[q] = 0; mu[q] = 0; mc[q] = 0;
  endtask

  task automatic add(input int q, input bit is_wr, input int v);
    int inc, size;
    inc  = (v > 63) ? 63 : v;
    size = 256 << mcode[q];
    if (v > 63) mc[q] = 1;
    if (is_wr) begin
      if (mocc[q] + inc > size) mo[q] = 1;
      else begin mw[q] = (mw[q] + inc) % size; mocc[q] += inc; end
    end else begin
      if (inc > mocc[q]) mu[q] = 1;
      else begin mr[q] = (mr[q] + inc) % size; mocc[q] -= inc; end
    end
    wr(qa(q, is_wr ? 4 : 0), 32'(v));
  endtask

  task automatic set_size(input int q, input int v);
    m_clear(q, (v > 10) ? 10 : v);
    wr(qa(q, 16), 32'(v));
  endtask

  task automatic chk_q(input int q, input string tag);
    logic [31:0] d;
    rd(qa(q, 8), d);
    check(d, {11'b0, mc[q], mu[q], mo[q], 18'(mr[q])}, {tag, " read ptr word"});
    rd(qa(q, 12), d);
    check(d, {11'b0, mc[q], mu[q], mo[q], 18'(mw[q])}, {tag, " write ptr word"});
    rd(qa(q, 16), d);
    check(d, 32'(mcode[q]), {tag, " size code"});
  endtask

  task automatic chk_all(input string tag);
    for (int q = 0; q < NQ; q++) chk_q(q, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int q = 0; q < NQ; q++) m_clear(q, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state of every queue
    chk_all("R9");

    // R2 R3 R4 sweep of add values on queue 0, ring of 256
    for (int v = 0; v <= 70; v++) begin
      add(0, 1, v);
      add(0, 0, v);
      chk_q(0, "R2/R4 sweep");
    end
    // R10 others untouched by queue 0 traffic
    chk_all("R10");

    // R5 overflow exactly at the ring size on queue 1
    for (int k = 0; k < 4; k++) add(1, 1, 63);
    add(1, 1, 10);
    chk_q(1, "R5 over by 6");
    add(1, 1, 4);
    chk_q(1, "R5 fill to 256");
    add(1, 1, 1);
    chk_q(1, "R5 over by 1");

    // R6 underflow on queue 2
    add(2, 1, 5);
    add(2, 0, 6);
    chk_q(2, "R6 under by 1");
    add(2, 0, 5);
    chk_q(2, "R6 drain exact");
    add(2, 0, 1);
    chk_q(2, "R6 under empty");

    // R7 code saturation and wrap on a 512 ring, queue 3
    set_size(3, 15);
    chk_q(3, "R7 saturate");
    set_size(3, 1);
    for (int k = 0; k < 20; k++) begin
      add(3, 1, 63);
      add(3, 0, 63);
      chk_q(3, "R7 wrap 512");
    end
    add(3, 1, 100);
    chk_q(3, "R4 clamp on 512");
    set_size(1, 0);
    chk_q(1, "R7 reconfig clears flags");
    chk_all("R10 after phases");

    // R1 unmapped accesses
    wr(qa(0, 20), 32'd7);
    wr(qa(1, 4) & 20'h7FFFF, 32'd7);
    wr(qa(5, 4), 32'd7);
    wr(qa(2, 16) & 20'h7FFFF, 32'd3);
    chk_all("R1 ignored writes");
    rd(qa(0, 20), d);
    check(d, 32'd0, "R1 bad offset read");
    rd(qa(5, 8), d);
    check(d, 32'd0, "R1 queue out of range read");
    rd(qa(0, 8) & 20'h7FFFF, d);
    check(d, 32'd0, "R1 outside region read");

    // R8 rvalid timing and read-before-write
    @(negedge clk);
    rd_en = 1'b1; addr = qa(0, 16);
    @(negedge clk);
    rd_en = 1'b0;
    check(32'(rvalid), 32'd1, "R8 rvalid after read");
    @(negedge clk);
    check(32'(rvalid), 32'd0, "R8 rvalid idle");
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; addr = qa(0, 16); wdata = 32'd2;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check(rdata, 32'(mcode[0]), "R8 read sees old code");
    m_clear(0, 2);
    chk_q(0, "R8 write applied");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule